// File: doc/BRIEF.md
# Two-Key Software Watchdog

This block watches over firmware by running a timeout counter that firmware must restart at regular intervals. To restart it, firmware writes a two-step key to a dedicated service register: first the arming value 0x55, then the completing value 0xAA. Any number of unrelated bus operations may fall between the two writes. If no completed key reaches the block before the counter runs out, the block raises a reset request for the system. The request stays high until the system reset arrives.

A small configuration register holds three settings. The first is an enable bit, and the counter only advances while it is set. The second is a slow-clock bit, which divides the clock by a power of two before counting. The third is a 2-bit period select. A new period select is only a request: it becomes the active period when the next key completes. The slow-clock bit comes out of reset with the level of a mode input. The bench shortens the divider and the periods through parameters. The defaults give a divide of 512 and periods of 2^9, 2^11, 2^13 and 2^15 ticks.

Top module: `twokey_wdog`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `resetReq` is 0. A configuration read (`rdSvc`=0) returns 0 in every bit except bit 1.
- R2: After reset, the slow-clock bit (configuration bit 1) holds the level that `modeIn` had at the last rising clock edge with `rst` high. Later changes of `modeIn` do not alter it.
- R3: The counter advances only while the enable bit (configuration bit 0) is 1. While it is 0 the count is held, no reset request is raised, and counting resumes from the held value when the bit is set again.
- R4: With the slow-clock bit at 0, `resetReq` rises exactly 2^(BASE_LOG2+STEP_LOG2*sel) enabled cycles after the edge that completed the last key, or after the edge that enabled the block from reset. Here sel is the active period. Once high, `resetReq` stays high until `rst`.
- R5: With the slow-clock bit at 1, each count takes 2^PRE_LOG2 clock cycles, so the timeout is that many times longer than in R4.
- R6: A write of 0x55 to the service register (`wrSvc`=1) arms the key. A later service write of 0xAA completes it and restarts the timeout. Configuration writes and reads between the two writes do not break the key.
- R7: A service write of 0xAA with no armed key has no effect. After 0x55, a service write of any value other than 0x55 or 0xAA disarms the key. A repeated 0x55 keeps it armed.
- R8: A service-register read (`rdSvc`=1) always returns 0. A configuration write takes bit 0 as enable, bit 1 as slow-clock and bits 3:2 as the requested period select. These bits read back in the same positions, with the upper bits read as 0.
- R9: A write to the period select does not change the active period until the next completed key. At that point the requested select becomes active. The active select is 0 after reset.
- R10: A key that completes on the same edge on which the timeout would fire restarts the counter, and `resetReq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modeIn | input | 1 | Mode level captured as the slow-clock bit during reset |
| wrEn | input | 1 | Write strobe |
| wrSvc | input | 1 | Write target: 1 service register, 0 configuration register |
| wrData | input | 8 | Write data |
| rdSvc | input | 1 | Read target: 1 service register, 0 configuration register |
| rdData | output | 8 | Read data, combinational |
| resetReq | output | 1 | Sticky system reset request |

## Verification
The timeout is measured in all four period selects with the divider off, and in three selects with it on. The exact cycle of the rise tells a wrong period or divider apart from an off-by-one in the reload. Key patterns include a bare 0xAA, 0x55 followed by a foreign value, a doubled 0x55, and a key with other register traffic between its halves. Each pattern shifts the timeout edge by a known amount, so a key that was wrongly accepted or wrongly refused shows up in the timing. Separate runs cover a held count across a disable, a period change without a key, and a key that lands on the timeout edge.

// File: rtl/twokey_wdog_pkg.sv
package twokey_wdog_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_FIRE = 8'hAA;

  // strobes and settings passed from control to datapath
  typedef struct packed {
    logic       reload;   // completed key this cycle
    logic       run;      // enable bit
    logic       slowClk;  // prescaler in use
    logic [1:0] period;   // active period select
  } wdStrobe_t;
endpackage

// File: rtl/twokey_wdog_ctrl.sv
module twokey_wdog_ctrl
  import twokey_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              modeIn,
  input  logic              wrEn,
  input  logic              wrSvc,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSvc,
  output logic [DATA_W-1:0] rdData,
  output wdStrobe_t         strobe
);
  logic       enBit;
  logic       slowBit;
  logic [1:0] reqSel;
  logic [1:0] actSel;
  logic       armed;
  logic       svcWr;
  logic       cfgWr;
  logic       keyDone;

  assign svcWr   = wrEn && wrSvc;
  assign cfgWr   = wrEn && !wrSvc;
  assign keyDone = svcWr && (wrData == KEY_FIRE) && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      enBit   <= 1'b0;
      slowBit <= modeIn;
      reqSel  <= 2'd0;
    end else if (cfgWr) begin
      enBit   <= wrData[0];
      slowBit <= wrData[1];
      reqSel  <= wrData[3:2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      actSel <= 2'd0;
    end else begin
      if (svcWr) begin
        if (wrData == KEY_ARM) armed <= 1'b1;
        else if (wrData != KEY_FIRE) armed <= 1'b0;
        else if (armed) armed <= 1'b0;
      end
      if (keyDone) actSel <= reqSel;
    end
  end

  assign rdData = rdSvc ? '0 : {{(DATA_W-4){1'b0}}, reqSel, slowBit, enBit};

  always_comb begin
    strobe.reload  = keyDone;
    strobe.run     = enBit;
    strobe.slowClk = slowBit;
    strobe.period  = actSel;
  end

  AST_SEL_LATCH: assert property (@(posedge clk) disable iff (rst)
    keyDone |=> (actSel == $past(reqSel))); // R9
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !keyDone |=> $stable(actSel)); // R9
  AST_KEY_ARM: assert property (@(posedge clk) disable iff (rst)
    (svcWr && wrData == KEY_ARM) |=> armed); // R6
  AST_KEY_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (svcWr && wrData != KEY_ARM && wrData != KEY_FIRE) |=> !armed); // R7
endmodule

// File: rtl/twokey_wdog_dp.sv
module twokey_wdog_dp
  import twokey_wdog_pkg::*;
#(
  parameter int PRE_LOG2  = 9,
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  wdStrobe_t strobe,
  output logic      resetReq
);
  localparam int CNT_W = BASE_LOG2 + 3 * STEP_LOG2;

  logic [PRE_LOG2-1:0] presc;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    limTab [4];
  logic [CNT_W-1:0]    limit;
  logic                preTick;
  logic                step;
  logic                hit;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign limTab[g] = CNT_W'((64'd1 << (BASE_LOG2 + STEP_LOG2 * g)) - 64'd1);
  end

  assign limit   = limTab[strobe.period];
  assign preTick = !strobe.slowClk || (presc == '1);
  assign step    = strobe.run && preTick;
  assign hit     = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || strobe.reload) presc <= '0;
    else if (strobe.run && strobe.slowClk) presc <= presc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.reload) cnt <= '0;
    else if (step && !hit) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) resetReq <= 1'b0;
    else if (step && hit && !strobe.reload) resetReq <= 1'b1;
  end

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    resetReq |=> resetReq); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit); // R4
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobe.reload |=> (cnt == '0)); // R6
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!strobe.run && !strobe.reload) |=> $stable(cnt)); // R3
  AST_SLOW_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobe.run && strobe.slowClk && !strobe.reload && presc != '1) |=> $stable(cnt)); // R5
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (strobe.reload && !resetReq) |=> !resetReq); // R10
endmodule

// File: rtl/twokey_wdog.sv
module twokey_wdog
  import twokey_wdog_pkg::*;
#(
  parameter int PRE_LOG2  = 9,
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       modeIn,
  input  logic       wrEn,
  input  logic       wrSvc,
  input  logic [7:0] wrData,
  input  logic       rdSvc,
  output logic [7:0] rdData,
  output logic       resetReq
);
  wdStrobe_t strobe;

  twokey_wdog_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .modeIn (modeIn),
    .wrEn   (wrEn),
    .wrSvc  (wrSvc),
    .wrData (wrData),
    .rdSvc  (rdSvc),
    .rdData (rdData),
    .strobe (strobe)
  );

  twokey_wdog_dp #(
    .PRE_LOG2  (PRE_LOG2),
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .resetReq (resetReq)
  );
endmodule

// File: tb/twokey_wdog_tb_top.sv
module twokey_wdog_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeIn = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSvc = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdSvc = 1'b0;
  logic [7:0] rdData;
  logic       resetReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // periods 8,16,32,64 counts; slow clock divides by 4
  twokey_wdog #(.PRE_LOG2(2), .BASE_LOG2(3), .STEP_LOG2(1)) dut_i (
    .clk(clk), .rst(rst), .modeIn(modeIn), .wrEn(wrEn), .wrSvc(wrSvc),
    .wrData(wrData), .rdSvc(rdSvc), .rdData(rdData), .resetReq(resetReq)
  );

  always #2 clk = ~clk;

  localparam int NVEC = 7;
  localparam int VSEL [NVEC] = '{0, 1, 2, 3, 0, 1, 3};
  localparam int VPRE [NVEC] = '{0, 0, 0, 0, 1, 1, 1};
  localparam int VCYC [NVEC] = '{8, 16, 32, 64, 32, 64, 256};

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rst = 1'b1; modeIn = mode; wrEn = 1'b0; rdSvc = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modeIn = !mode;
  endtask

  // drive at the current negedge, sampled at the next posedge
  task automatic wrNow(input logic svc, input logic [7:0] d);
    wrEn = 1'b1; wrSvc = svc; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrReg(input logic svc, input logic [7:0] d);
    @(negedge clk);
    wrNow(svc, d);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 / R2: reset state and mode capture
    doReset(1'b1);
    chk(resetReq, 1'b0, "R1 request after reset");
    rdSvc = 1'b0; #0;
    chk(rdData, 8'h02, "R2 slow bit from mode=1");
    waitN(3);
    chk(rdData, 8'h02, "R2 mode change ignored");
    doReset(1'b0);
    chk(rdData, 8'h00, "R1 config read after reset");

    // R8: service register reads zero
    wrReg(1'b1, 8'h55);
    rdSvc = 1'b1; #1;
    chk(rdData, 8'h00, "R8 service read");
    rdSvc = 1'b0;
    wrReg(1'b0, 8'b0000_1110);
    #1;
    chk(rdData, 8'h0E, "R8 config readback");

    // R4/R5/R9: period table walk
    for (int i = 0; i < NVEC; i++) begin
      doReset(1'b0);
      wrReg(1'b0, {4'b0, 2'(VSEL[i]), 1'(VPRE[i]), 1'b1});
      wrReg(1'b1, 8'h55);
      wrReg(1'b1, 8'hAA);
      waitN(VCYC[i] - 1);
      chk(resetReq, 1'b0, (VPRE[i] != 0) ? "R5 early edge" : "R4 early edge");
      waitN(1);
      chk(resetReq, 1'b1, (VPRE[i] != 0) ? "R5 timeout edge" : "R4 timeout edge");
    end

    // R4: sticky after timeout even with a key
    wrReg(1'b1, 8'h55);
    wrReg(1'b1, 8'hAA);
    waitN(2);
    chk(resetReq, 1'b1, "R4 sticky request");

    // R3: disabled never times out
    doReset(1'b0);
    waitN(200);
    chk(resetReq, 1'b0, "R3 disabled idle");

    // R3: count held across disable
    wrReg(1'b0, 8'h01);
    wrReg(1'b1, 8'h55);
    wrReg(1'b1, 8'hAA);
    wrReg(1'b0, 8'h00);
    waitN(50);
    chk(resetReq, 1'b0, "R3 held while off");
    wrReg(1'b0, 8'h01);
    waitN(5);
    chk(resetReq, 1'b0, "R3 resume early");
    waitN(1);
    chk(resetReq, 1'b1, "R3 resume from held count");

    // R6: other traffic between the two key writes
    doReset(1'b0);
    wrReg(1'b0, 8'h01);
    wrReg(1'b1, 8'h55);
    wrReg(1'b0, 8'h01);
    rdSvc = 1'b1; #1; rdSvc = 1'b0;
    wrReg(1'b1, 8'hAA);
    waitN(7);
    chk(resetReq, 1'b0, "R6 key with traffic early");
    waitN(1);
    chk(resetReq, 1'b1, "R6 key with traffic edge");

    // R7: bare 0xAA does nothing
    doReset(1'b0);
    wrReg(1'b0, 8'h01);
    wrReg(1'b1, 8'hAA);
    waitN(5);
    chk(resetReq, 1'b0, "R7 bare AA early");
    waitN(1);
    chk(resetReq, 1'b1, "R7 bare AA no reload");

    // R7: foreign value disarms
    doReset(1'b0);
    wrReg(1'b0, 8'h01);
    wrReg(1'b1, 8'h55);
    wrReg(1'b1, 8'h12);
    wrReg(1'b1, 8'hAA);
    waitN(1);
    chk(resetReq, 1'b0, "R7 cancel early");
    waitN(1);
    chk(resetReq, 1'b1, "R7 cancelled key");

    // R7: repeated 0x55 stays armed
    doReset(1'b0);
    wrReg(1'b0, 8'h01);
    wrReg(1'b1, 8'h55);
    wrReg(1'b1, 8'h55);
    wrReg(1'b1, 8'hAA);
    waitN(7);
    chk(resetReq, 1'b0, "R7 double arm early");
    waitN(1);
    chk(resetReq, 1'b1, "R7 double arm reload");

    // R9: period select without key keeps old period
    doReset(1'b0);
    wrReg(1'b0, 8'b0000_1101);
    waitN(7);
    chk(resetReq, 1'b0, "R9 pending select early");
    waitN(1);
    chk(resetReq, 1'b1, "R9 old period still active");

    // R10: key lands on the timeout edge
    doReset(1'b0);
    wrReg(1'b0, 8'h01);
    wrReg(1'b1, 8'h55);
    waitN(5);
    wrNow(1'b1, 8'hAA);
    chk(resetReq, 1'b0, "R10 key on timeout edge");
    waitN(7);
    chk(resetReq, 1'b0, "R10 after reload early");
    waitN(1);
    chk(resetReq, 1'b1, "R10 after reload edge");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule